// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block works out the processor state changes for taking an exception and for returning from one. Each clock it samples seven exception request lines, the current status word and the address to store as the return link. When one or more exceptions are pending, it picks the most urgent one. In the next cycle it issues four write strobes together:

- a copy of the old status word for the saved-status bank of the target mode;
- the new status word, with the mode switched, the 32-bit instruction state forced and the interrupt masks updated;
- the link value for the target mode;
- the vector address for the program counter.

A return request with no exception pending restores the status word from the saved-status input and loads the program counter from the link input. This is allowed only when the current state is the 32-bit instruction state. The register banks and instruction fetch sit outside the block. The block only produces the values and strobes that update them.

Top module: `exc_seq`

## Requirements
- R1: While `rst` is high at a rising edge, all four strobes and all data outputs are cleared to zero in the following cycle.
- R2: Priority among pending requests, highest first: reset, data abort, FIQ, IRQ, prefetch abort, undefined instruction, software interrupt.
- R3: An IRQ request is ignored while bit 7 (I) of `cur_psr` is set. An FIQ request is ignored while bit 6 (F) is set. A masked request gives way to the next request down the priority list.
- R4: On entry, `spsr_wr` pulses and `spsr_data` equals `cur_psr` as sampled at the request edge.
- R5: On entry, `psr_new[4:0]` holds the target mode and `psr_new[5]` (T) is 0. Bits 31:8 are copied from `cur_psr`. The mode encodings are: FIQ 5'b10001, IRQ 5'b10010, supervisor 5'b10011 (for reset and software interrupt), abort 5'b10111 (for both aborts) and undefined 5'b11011.
- R6: Every entry sets `psr_new[7]` (I). FIQ and reset entries also set `psr_new[6]` (F). All other entries copy F from `cur_psr`.
- R7: On entry, `lr_wr` pulses and `lr_data` equals `ret_addr` as sampled at the request edge.
- R8: On entry, `pc_new` is the vector base plus the offset. The offsets are: reset 0x00, undefined 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, IRQ 0x18, FIQ 0x1C. The base is 0xFFFF0000 when `high_vec` is 1 and 0x00000000 when it is 0. Offset 0x14 is never produced.
- R9: An entry is taken at the rising edge where its request is sampled. All four strobes are high together for exactly the one following cycle. With no request and no return, the strobes stay low.
- R10: A return with no exception pending and `cur_psr[5]`=0 pulses `psr_wr` and `pc_wr` only. In that cycle, `psr_new` equals `spsr_in` and `pc_new` equals `lr_in`.
- R11: A return request is ignored while `cur_psr[5]`=1: no strobe pulses.
- R12: When an exception request and a return request are both present, the exception entry is taken and the return is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_reset | input | 1 | Reset exception request |
| req_undef | input | 1 | Undefined instruction request |
| req_swi | input | 1 | Software interrupt request |
| req_pabt | input | 1 | Prefetch abort request |
| req_dabt | input | 1 | Data abort request |
| req_irq | input | 1 | Normal interrupt request |
| req_fiq | input | 1 | Fast interrupt request |
| high_vec | input | 1 | Selects the high vector base |
| ret_req | input | 1 | Return-from-exception request |
| cur_psr | input | 32 | Current status word |
| ret_addr | input | 32 | Link value to store on entry |
| spsr_in | input | 32 | Saved status word of the current mode |
| lr_in | input | 32 | Link register of the current mode |
| psr_wr | output | 1 | Status word write strobe |
| psr_new | output | 32 | New status word |
| spsr_wr | output | 1 | Saved-status write strobe |
| spsr_data | output | 32 | Value for the saved-status bank |
| lr_wr | output | 1 | Link register write strobe |
| lr_data | output | 32 | Value for the link register |
| pc_wr | output | 1 | Program counter load strobe |
| pc_new | output | 32 | New program counter |

## Verification
All state sits in one rank of output registers, so any wrong internal decision shows at the ports in the cycle right after the request edge. A priority or masking fault shows as a wrong vector offset or mode field. A wrong mask update shows in bits 7:6 of the new status word. A lost or stray strobe shows as a strobe pattern other than all four together, or the return pair alone. A missed reset clear shows in the first cycle after reset.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int PSR_W    = 32;
  localparam int MODE_W   = 5;
  localparam int BIT_T    = 5;
  localparam int BIT_F    = 6;
  localparam int BIT_I    = 7;
  localparam int NUM_SRC  = 7;

  // Encoding equals the vector slot: offset = kind * 4
  typedef enum logic [2:0] {
    EK_RESET = 3'd0,
    EK_UNDEF = 3'd1,
    EK_SWI   = 3'd2,
    EK_PABT  = 3'd3,
    EK_DABT  = 3'd4,
    EK_IRQ   = 3'd6,
    EK_FIQ   = 3'd7
  } exc_kind_e;

  localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;

  // Priority slot i (0 = most urgent) -> exception kind
  function automatic exc_kind_e kind_at(input int slot);
    case (slot)
      0:       kind_at = EK_RESET;
      1:       kind_at = EK_DABT;
      2:       kind_at = EK_FIQ;
      3:       kind_at = EK_IRQ;
      4:       kind_at = EK_PABT;
      5:       kind_at = EK_UNDEF;
      default: kind_at = EK_SWI;
    endcase
  endfunction
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
#(
  parameter int N = NUM_SRC
) (
  input  logic [N-1:0] req_prio,  // bit 0 most urgent
  output logic         hit,
  output exc_kind_e    kind
);
  always_comb begin
    hit  = |req_prio;
    kind = EK_SWI;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_prio[i]) kind = kind_at(i);
    end
  end
endmodule

// File: rtl/exc_entry_calc.sv
module exc_entry_calc
  import exc_pkg::*;
#(
  parameter int          XLEN    = PSR_W,
  parameter logic [31:0] HI_BASE = 32'hFFFF_0000
) (
  input  exc_kind_e       kind,
  input  logic            high_vec,
  input  logic [XLEN-1:8] psr_keep,
  input  logic            f_cur,
  output logic [XLEN-1:0] psr_out,
  output logic [XLEN-1:0] vec_pc
);
  localparam int OFS_W = 5;

  logic [MODE_W-1:0] mode;
  logic              f_new;
  logic [XLEN-1:0]   base;

  always_comb begin
    case (kind)
      EK_FIQ:          mode = MODE_FIQ;
      EK_IRQ:          mode = MODE_IRQ;
      EK_PABT,
      EK_DABT:         mode = MODE_ABT;
      EK_UNDEF:        mode = MODE_UND;
      default:         mode = MODE_SVC;
    endcase
  end

  assign f_new   = (kind == EK_FIQ) || (kind == EK_RESET) || f_cur;
  assign psr_out = {psr_keep, 1'b1, f_new, 1'b0, mode};

  generate
    if (XLEN > 32) begin : g_wide
      assign base = high_vec ? {{(XLEN-32){1'b1}}, HI_BASE} : '0;
    end else begin : g_narrow
      assign base = high_vec ? HI_BASE[XLEN-1:0] : '0;
    end
  endgenerate

  assign vec_pc = base | {{(XLEN-OFS_W){1'b0}}, kind, 2'b00};
endmodule

// File: rtl/exc_seq.sv
module exc_seq
  import exc_pkg::*;
#(
  parameter int XLEN = PSR_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_reset,
  input  logic            req_undef,
  input  logic            req_swi,
  input  logic            req_pabt,
  input  logic            req_dabt,
  input  logic            req_irq,
  input  logic            req_fiq,
  input  logic            high_vec,
  input  logic            ret_req,
  input  logic [XLEN-1:0] cur_psr,
  input  logic [XLEN-1:0] ret_addr,
  input  logic [XLEN-1:0] spsr_in,
  input  logic [XLEN-1:0] lr_in,
  output logic            psr_wr,
  output logic [XLEN-1:0] psr_new,
  output logic            spsr_wr,
  output logic [XLEN-1:0] spsr_data,
  output logic            lr_wr,
  output logic [XLEN-1:0] lr_data,
  output logic            pc_wr,
  output logic [XLEN-1:0] pc_new
);
  logic [NUM_SRC-1:0] req_prio;
  logic               hit;
  exc_kind_e          kind;
  logic [XLEN-1:0]    entry_psr;
  logic [XLEN-1:0]    entry_pc;
  logic               ret_ok;

  // Priority slots, masked interrupts removed
  assign req_prio = {req_swi, req_undef, req_pabt,
                     req_irq & ~cur_psr[BIT_I],
                     req_fiq & ~cur_psr[BIT_F],
                     req_dabt, req_reset};

  assign ret_ok = ret_req & ~cur_psr[BIT_T];

  exc_arbiter #(.N(NUM_SRC)) i_arb (
    .req_prio (req_prio),
    .hit      (hit),
    .kind     (kind)
  );

  exc_entry_calc #(.XLEN(XLEN)) i_calc (
    .kind     (kind),
    .high_vec (high_vec),
    .psr_keep (cur_psr[XLEN-1:8]),
    .f_cur    (cur_psr[BIT_F]),
    .psr_out  (entry_psr),
    .vec_pc   (entry_pc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      psr_wr    <= 1'b0;
      spsr_wr   <= 1'b0;
      lr_wr     <= 1'b0;
      pc_wr     <= 1'b0;
      psr_new   <= '0;
      spsr_data <= '0;
      lr_data   <= '0;
      pc_new    <= '0;
    end else begin
      psr_wr  <= 1'b0;
      spsr_wr <= 1'b0;
      lr_wr   <= 1'b0;
      pc_wr   <= 1'b0;
      if (hit) begin
        psr_wr    <= 1'b1;
        spsr_wr   <= 1'b1;
        lr_wr     <= 1'b1;
        pc_wr     <= 1'b1;
        psr_new   <= entry_psr;
        spsr_data <= cur_psr;
        lr_data   <= ret_addr;
        pc_new    <= entry_pc;
      end else if (ret_ok) begin
        psr_wr  <= 1'b1;
        pc_wr   <= 1'b1;
        psr_new <= spsr_in;
        pc_new  <= lr_in;
      end
    end
  end
endmodule

// File: rtl/exc_seq_chk.sv
module exc_seq_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            req_reset,
  input logic            req_undef,
  input logic            req_swi,
  input logic            req_pabt,
  input logic            req_dabt,
  input logic            req_irq,
  input logic            req_fiq,
  input logic            high_vec,
  input logic            ret_req,
  input logic [XLEN-1:0] cur_psr,
  input logic [XLEN-1:0] ret_addr,
  input logic [XLEN-1:0] spsr_in,
  input logic [XLEN-1:0] lr_in,
  input logic            psr_wr,
  input logic [XLEN-1:0] psr_new,
  input logic            spsr_wr,
  input logic [XLEN-1:0] spsr_data,
  input logic            lr_wr,
  input logic [XLEN-1:0] lr_data,
  input logic            pc_wr,
  input logic [XLEN-1:0] pc_new
);
  logic any_req;
  assign any_req = req_reset | req_undef | req_swi | req_pabt |
                   req_dabt | req_irq | req_fiq;

  a_r9_strobes_together: assert property (@(posedge clk) disable iff (rst)
    spsr_wr |-> (psr_wr && lr_wr && pc_wr));

  a_r9_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
    $past(!any_req && !ret_req) |-> !psr_wr && !pc_wr);

  a_r4_spsr_copy: assert property (@(posedge clk) disable iff (rst)
    spsr_wr |-> spsr_data == $past(cur_psr));

  a_r7_link_value: assert property (@(posedge clk) disable iff (rst)
    lr_wr |-> lr_data == $past(ret_addr));

  a_r5_arm_state: assert property (@(posedge clk) disable iff (rst)
    spsr_wr |-> (!psr_new[5] && psr_new[7] &&
                 psr_new[XLEN-1:8] == $past(cur_psr[XLEN-1:8])));

  a_r8_vector_base: assert property (@(posedge clk) disable iff (rst)
    spsr_wr |-> (pc_new[1:0] == 2'b00 && pc_new[4:2] != 3'd5 &&
                 pc_new[15:5] == '0 &&
                 pc_new[31:16] == ($past(high_vec) ? 16'hFFFF : 16'h0000)));

  a_r3_irq_masked: assert property (@(posedge clk) disable iff (rst)
    $past(req_irq && cur_psr[7] && !ret_req && !req_reset && !req_undef &&
          !req_swi && !req_pabt && !req_dabt && !req_fiq) |-> !psr_wr);

  a_r10_return_values: assert property (@(posedge clk) disable iff (rst)
    (psr_wr && !spsr_wr) |-> (psr_new == $past(spsr_in) &&
                              pc_new == $past(lr_in) && pc_wr && !lr_wr));

  a_r11_thumb_return: assert property (@(posedge clk) disable iff (rst)
    $past(ret_req && cur_psr[5] && !any_req) |-> !psr_wr);

  a_r12_entry_wins: assert property (@(posedge clk) disable iff (rst)
    $past(ret_req && (req_reset || req_dabt || req_undef)) |-> spsr_wr);
endmodule

bind exc_seq exc_seq_chk #(.XLEN(XLEN)) i_chk (
  .clk(clk), .rst(rst), .req_reset(req_reset), .req_undef(req_undef),
  .req_swi(req_swi), .req_pabt(req_pabt), .req_dabt(req_dabt),
  .req_irq(req_irq), .req_fiq(req_fiq), .high_vec(high_vec),
  .ret_req(ret_req), .cur_psr(cur_psr), .ret_addr(ret_addr),
  .spsr_in(spsr_in), .lr_in(lr_in), .psr_wr(psr_wr), .psr_new(psr_new),
  .spsr_wr(spsr_wr), .spsr_data(spsr_data), .lr_wr(lr_wr),
  .lr_data(lr_data), .pc_wr(pc_wr), .pc_new(pc_new)
);

// File: tb/test_exc_seq.sv
module test_exc_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_reset = 0, req_undef = 0, req_swi = 0, req_pabt = 0;
  logic        req_dabt = 0, req_irq = 0, req_fiq = 0;
  logic        high_vec = 0, ret_req = 0;
  logic [31:0] cur_psr = 0, ret_addr = 0, spsr_in = 0, lr_in = 0;
  logic        psr_wr, spsr_wr, lr_wr, pc_wr;
  logic [31:0] psr_new, spsr_data, lr_data, pc_new;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  exc_seq i_exc_seq (
    .clk(clk), .rst(rst), .req_reset(req_reset), .req_undef(req_undef),
    .req_swi(req_swi), .req_pabt(req_pabt), .req_dabt(req_dabt),
    .req_irq(req_irq), .req_fiq(req_fiq), .high_vec(high_vec),
    .ret_req(ret_req), .cur_psr(cur_psr), .ret_addr(ret_addr),
    .spsr_in(spsr_in), .lr_in(lr_in), .psr_wr(psr_wr), .psr_new(psr_new),
    .spsr_wr(spsr_wr), .spsr_data(spsr_data), .lr_wr(lr_wr),
    .lr_data(lr_data), .pc_wr(pc_wr), .pc_new(pc_new)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clear_in();
    {req_reset, req_undef, req_swi, req_pabt, req_dabt, req_irq, req_fiq} = '0;
    ret_req = 0;
  endtask

  // inputs set at a negedge; one posedge registers; sample at next negedge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // expected entry outcome computed from R4..R8
  task automatic exp_entry(input string tag, input logic [4:0] mode,
                           input logic [4:0] ofs, input logic fset);
    logic [31:0] ep;
    logic [31:0] epc;
    ep  = {cur_psr[31:8], 1'b1, fset | cur_psr[6], 1'b0, mode};
    epc = (high_vec ? 32'hFFFF_0000 : 32'h0) | {27'd0, ofs};
    step();
    chk({tag, " R9 strobes"}, {28'd0, psr_wr, spsr_wr, lr_wr, pc_wr}, 32'hF);
    chk({tag, " R4 spsr"}, spsr_data, cur_psr);
    chk({tag, " R5/R6 psr"}, psr_new, ep);
    chk({tag, " R7 lr"}, lr_data, ret_addr);
    chk({tag, " R8 pc"}, pc_new, epc);
    clear_in();
    step();
    chk({tag, " R9 single pulse"}, {28'd0, psr_wr, spsr_wr, lr_wr, pc_wr}, 32'h0);
  endtask

  task automatic t_reset();
    step();
    chk("R1 strobes", {28'd0, psr_wr, spsr_wr, lr_wr, pc_wr}, 32'h0);
    chk("R1 pc", pc_new, 32'h0);
    chk("R1 psr", psr_new, 32'h0);
    rst = 0;
  endtask

  task automatic t_singles();
    cur_psr = 32'h6000_0010; ret_addr = 32'h0000_1234;
    req_reset = 1; exp_entry("R5 reset", 5'b10011, 5'h00, 1);
    req_undef = 1; exp_entry("R5 undef", 5'b11011, 5'h04, 0);
    req_swi   = 1; exp_entry("R5 swi",   5'b10011, 5'h08, 0);
    req_pabt  = 1; exp_entry("R5 pabt",  5'b10111, 5'h0C, 0);
    req_dabt  = 1; exp_entry("R5 dabt",  5'b10111, 5'h10, 0);
    req_irq   = 1; exp_entry("R5 irq",   5'b10010, 5'h18, 0);
    req_fiq   = 1; exp_entry("R6 fiq",   5'b10001, 5'h1C, 1);
  endtask

  task automatic t_highvec();
    high_vec = 1; cur_psr = 32'h9000_001F; ret_addr = 32'hABCD_0004;
    req_irq = 1; exp_entry("R8 high irq", 5'b10010, 5'h18, 0);
    req_reset = 1; exp_entry("R8 high reset", 5'b10011, 5'h00, 1);
    high_vec = 0;
  endtask

  task automatic t_priority();
    cur_psr = 32'h0000_0010; ret_addr = 32'h40;
    {req_reset, req_undef, req_swi, req_pabt, req_dabt, req_irq, req_fiq} = '1;
    exp_entry("R2 all", 5'b10011, 5'h00, 1);
    req_dabt = 1; req_fiq = 1; req_irq = 1; req_pabt = 1;
    exp_entry("R2 dabt", 5'b10111, 5'h10, 0);
    req_fiq = 1; req_irq = 1; req_pabt = 1;
    exp_entry("R2 fiq", 5'b10001, 5'h1C, 1);
    req_irq = 1; req_pabt = 1; req_swi = 1;
    exp_entry("R2 irq", 5'b10010, 5'h18, 0);
    req_pabt = 1; req_undef = 1;
    exp_entry("R2 pabt", 5'b10111, 5'h0C, 0);
    req_undef = 1; req_swi = 1;
    exp_entry("R2 undef", 5'b11011, 5'h04, 0);
  endtask

  task automatic t_masking();
    cur_psr = 32'h0000_0093;  // I set
    req_irq = 1; step();
    chk("R3 irq masked", {31'd0, psr_wr}, 32'h0);
    clear_in();
    cur_psr = 32'h0000_0053;  // F set, I clear
    req_fiq = 1; req_irq = 1; ret_addr = 32'h88;
    exp_entry("R3 fiq masked irq taken", 5'b10010, 5'h18, 0);
    cur_psr = 32'h0000_00D3;  // both set, pabt below
    req_fiq = 1; req_irq = 1; req_pabt = 1;
    exp_entry("R3 both masked pabt", 5'b10111, 5'h0C, 0);
  endtask

  task automatic t_return();
    cur_psr = 32'h0000_0092; spsr_in = 32'h2000_0010; lr_in = 32'h0000_8000;
    ret_req = 1; step();
    chk("R10 strobes", {28'd0, psr_wr, spsr_wr, lr_wr, pc_wr}, 32'h9);
    chk("R10 psr", psr_new, 32'h2000_0010);
    chk("R10 pc", pc_new, 32'h0000_8000);
    clear_in();
    cur_psr = 32'h0000_00B2;  // T set
    ret_req = 1; step();
    chk("R11 ignored", {28'd0, psr_wr, spsr_wr, lr_wr, pc_wr}, 32'h0);
    clear_in();
    cur_psr = 32'h0000_0012; ret_addr = 32'h500;
    ret_req = 1; req_undef = 1;
    exp_entry("R12 entry wins", 5'b11011, 5'h04, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_singles();
    t_highvec();
    t_priority();
    t_masking();
    t_return();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule